// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address. It reads one 64-bit entry from each level of a four-level tree of page tables held in memory. A request carries the virtual address, two access flags (write and user) and the root table base. The walker then issues entry reads over a simple valid/ready memory port. Each read addresses one entry inside a 4096-byte-aligned table of 512 entries.

The walk ends in one of three ways. It ends at a level-1 leaf with a 4 KiB page. It ends early at a huge entry with a 2 MiB or 1 GiB page. It ends with a fault. The result is held on a valid/ready response port until the consumer takes it. The walker handles one translation at a time and raises `busy` for the whole walk. It only reads tables and never writes them back. Caching of translations is done elsewhere.

Top module: `pt_walker`

## Requirements
- R1: After reset, `busy`, `memReqValid` and `rspValid` are all low.
- R2: A request is non-canonical when bits 63:47 of its address are not all equal. Such a request completes with `rspCause` = 1 and `rspFault` high, and no memory read is issued for it.
- R3: The first read goes to `rootBase[47:12]` concatenated with the level-4 index and three zero bits. Each later read uses the frame in bits 47:12 of the previous entry. The level indices are address bits 47:39 (level 4), 38:30 (level 3), 29:21 (level 2) and 20:12 (level 1). A 4 KiB translation takes exactly four reads.
- R4: A 4 KiB result has `rspPaddr` = {leaf entry bits 47:12, address bits 11:0}, `rspSize` = 0 and `rspCause` = 0.
- R5: An entry whose bit 0 (present) is clear ends the walk with `rspCause` = 2. No further read is made.
- R6: An entry with bit 7 (huge) set ends the walk early. At level 2 the result is a 2 MiB page: `rspPaddr` = {entry bits 47:21, address bits 20:0}, `rspSize` = 1, three reads. At level 3 it is a 1 GiB page: `rspPaddr` = {entry bits 47:30, address bits 29:0}, `rspSize` = 2, two reads.
- R7: Bit 7 of a level-1 entry has no effect. That entry is still treated as a 4 KiB leaf.
- R8: For a write request, every entry on the path must have bit 1 (writable) set. For a user request, every entry must have bit 2 (user) set. The first entry that fails ends the walk with `rspCause` = 3, and no further read is made.
- R9: `busy` goes high on the cycle after a request is accepted and stays high until the response handshake. A `reqValid` raised while `busy` is high is ignored.
- R10: While `rspValid` is high and `rspReady` is low, `rspValid`, `rspPaddr`, `rspCause` and `rspSize` hold steady. `rspFault` is high exactly when `rspCause` is nonzero.
- R11: While `memReqValid` is high and `memReqReady` is low, `memReqValid` and `memReqAddr` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Translation request strobe, taken when `busy` is low |
| reqVaddr | input | 64 | Virtual address to translate |
| reqWrite | input | 1 | Request needs write permission |
| reqUser | input | 1 | Request needs user permission |
| rootBase | input | 64 | Root table base; bits 47:12 used |
| busy | output | 1 | Walk in progress, new requests ignored |
| memReqValid | output | 1 | Entry read request |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | 48 | Byte address of the entry |
| memRspValid | input | 1 | Entry data valid |
| memRspData | input | 64 | Entry value |
| rspValid | output | 1 | Translation result valid |
| rspReady | input | 1 | Consumer takes the result |
| rspPaddr | output | 48 | Physical address (zero on fault) |
| rspFault | output | 1 | Walk faulted |
| rspCause | output | 2 | 0 none, 1 non-canonical, 2 not present, 3 permission |
| rspSize | output | 2 | 0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB |

## Verification
The assertions assume the memory side follows a simple rule. It returns exactly one `memRspValid` pulse for each accepted read, and it never sends a response while no read is pending. The read-count properties hold only under that rule. The bench's memory model captures the address only when the walker presents a read. It replies once, one cycle after acceptance or after a deliberate stall with `memReqReady` held low. It never drives `memRspValid` otherwise, so every stimulus stays within that rule.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_NONCANON = 2'd1,
    CAUSE_ABSENT   = 2'd2,
    CAUSE_PERM     = 2'd3
  } faultCause_t;

  typedef enum logic [1:0] {
    SIZE_4K = 2'd0,
    SIZE_2M = 2'd1,
    SIZE_1G = 2'd2
  } pageSize_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic        capture;
    logic        descend;
    logic        finish;
    faultCause_t cause;
  } walkStrobe_t;

  localparam int FLAG_PRESENT = 0;
  localparam int FLAG_WRITE   = 1;
  localparam int FLAG_USER    = 2;
  localparam int FLAG_HUGE    = 7;

endpackage

// File: rtl/pt_walk_datapath.sv
module pt_walk_datapath
  import pt_walk_pkg::*;
#(
  parameter int VA_W     = 64,
  parameter int PA_W     = 48,
  parameter int ENTRY_W  = 64,
  parameter int LEVELS   = 4,
  parameter int IDX_W    = 9,
  parameter int OFF_W    = 12,
  parameter int HUGE_TOP = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  walkStrobe_t         strobe,
  input  logic [VA_W-1:0]     reqVaddr,
  input  logic                reqWrite,
  input  logic                reqUser,
  input  logic [VA_W-1:0]     rootBase,
  input  logic [ENTRY_W-1:0]  memRspData,
  output logic                inCanonical,
  output logic                entryPresent,
  output logic                entryPermOk,
  output logic                entryHuge,
  output logic                atLeaf,
  output logic [PA_W-1:0]     memReqAddr,
  output logic [PA_W-1:0]     rspPaddr,
  output faultCause_t         rspCause,
  output pageSize_t           rspSize
);

  localparam int VA_USED  = OFF_W + LEVELS * IDX_W;
  localparam int LVL_W    = $clog2(LEVELS);
  localparam int FRAME_W  = PA_W - OFF_W;
  localparam int ENTRY_SH = OFF_W - IDX_W;

  logic [VA_USED-1:0] vaddrQ;
  logic               wantWrite;
  logic               wantUser;
  logic [FRAME_W-1:0] tableBase;
  logic [LVL_W-1:0]   levelQ;
  logic [PA_W-1:0]    paddrQ;
  faultCause_t        causeQ;
  pageSize_t          sizeQ;

  logic [IDX_W-1:0]   levelIdx [LEVELS];

  generate
    for (genvar g = 0; g < LEVELS; g++) begin : gIdx
      assign levelIdx[g] = vaddrQ[OFF_W + g*IDX_W +: IDX_W];
    end
  endgenerate

  // canonical when the unused top bits copy the highest translated bit
  logic [VA_W-VA_USED:0] upperBits;
  assign upperBits   = reqVaddr[VA_W-1:VA_USED-1];
  assign inCanonical = (&upperBits) || !(|upperBits);

  logic [FRAME_W-1:0] entryFrame;
  assign entryFrame   = memRspData[PA_W-1:OFF_W];
  assign entryPresent = memRspData[FLAG_PRESENT];
  assign entryPermOk  = (!wantWrite || memRspData[FLAG_WRITE]) &&
                        (!wantUser  || memRspData[FLAG_USER]);
  assign atLeaf       = (levelQ == '0);
  assign entryHuge    = memRspData[FLAG_HUGE] && !atLeaf &&
                        (int'(levelQ) <= HUGE_TOP);

  assign memReqAddr = {tableBase, levelIdx[levelQ], {ENTRY_SH{1'b0}}};

  // bits below the mapping size come from the virtual address
  logic [PA_W-1:0] leafMask;
  logic [PA_W-1:0] vaddrExt;
  logic [PA_W-1:0] leafPaddr;
  assign leafMask  = {PA_W{1'b1}} << (OFF_W + IDX_W * int'(levelQ));
  assign vaddrExt  = PA_W'(vaddrQ);
  assign leafPaddr = ({entryFrame, {OFF_W{1'b0}}} & leafMask) |
                     (vaddrExt & ~leafMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaddrQ    <= '0;
      wantWrite <= 1'b0;
      wantUser  <= 1'b0;
      tableBase <= '0;
      levelQ    <= '0;
      paddrQ    <= '0;
      causeQ    <= CAUSE_NONE;
      sizeQ     <= SIZE_4K;
    end else begin
      if (strobe.capture) begin
        vaddrQ    <= reqVaddr[VA_USED-1:0];
        wantWrite <= reqWrite;
        wantUser  <= reqUser;
        tableBase <= rootBase[PA_W-1:OFF_W];
        levelQ    <= LVL_W'(LEVELS - 1);
      end else if (strobe.descend) begin
        tableBase <= entryFrame;
        levelQ    <= levelQ - 1'b1;
      end
      if (strobe.finish) begin
        causeQ <= strobe.cause;
        if (strobe.cause == CAUSE_NONE) begin
          paddrQ <= leafPaddr;
          sizeQ  <= pageSize_t'(levelQ);
        end else begin
          paddrQ <= '0;
          sizeQ  <= SIZE_4K;
        end
      end
    end
  end

  assign rspPaddr = paddrQ;
  assign rspCause = causeQ;
  assign rspSize  = sizeQ;

  logic unusedBits;
  assign unusedBits = ^{rootBase[VA_W-1:PA_W], rootBase[OFF_W-1:0],
                        memRspData[ENTRY_W-1:PA_W],
                        memRspData[OFF_W-1:FLAG_HUGE+1],
                        memRspData[FLAG_HUGE-1:FLAG_USER+1]};

  AST_DESCEND_ABOVE_LEAF: assert property (@(posedge clk) disable iff (!rstN)
    strobe.descend |-> levelQ != '0); // R3

  AST_CAPTURE_NOT_MIDWALK: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |-> !strobe.descend); // R9

endmodule

// File: rtl/pt_walk_control.sv
module pt_walk_control
  import pt_walk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        inCanonical,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic        entryPresent,
  input  logic        entryPermOk,
  input  logic        entryHuge,
  input  logic        atLeaf,
  input  logic        rspReady,
  output walkStrobe_t strobe,
  output logic        busy,
  output logic        memReqValid,
  output logic        rspValid
);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_WAIT = 2'd2,
    ST_RESP = 2'd3
  } walkState_t;

  walkState_t state, nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.capture = 1'b1;
          if (!inCanonical) begin
            strobe.finish = 1'b1;
            strobe.cause  = CAUSE_NONCANON;
            nextState     = ST_RESP;
          end else begin
            nextState = ST_READ;
          end
        end
      end
      ST_READ: begin
        if (memReqReady) nextState = ST_WAIT;
      end
      ST_WAIT: begin
        if (memRspValid) begin
          if (!entryPresent) begin
            strobe.finish = 1'b1;
            strobe.cause  = CAUSE_ABSENT;
            nextState     = ST_RESP;
          end else if (!entryPermOk) begin
            strobe.finish = 1'b1;
            strobe.cause  = CAUSE_PERM;
            nextState     = ST_RESP;
          end else if (entryHuge || atLeaf) begin
            strobe.finish = 1'b1;
            strobe.cause  = CAUSE_NONE;
            nextState     = ST_RESP;
          end else begin
            strobe.descend = 1'b1;
            nextState      = ST_READ;
          end
        end
      end
      ST_RESP: begin
        if (rspReady) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign busy        = (state != ST_IDLE);
  assign memReqValid = (state == ST_READ);
  assign rspValid    = (state == ST_RESP);

  AST_MEMREQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid); // R11

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid); // R10

  AST_FINISH_ONE_HOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.finish && !strobe.capture, strobe.descend})); // R5

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int VA_W     = 64,
  parameter int PA_W     = 48,
  parameter int ENTRY_W  = 64,
  parameter int LEVELS   = 4,
  parameter int IDX_W    = 9,
  parameter int OFF_W    = 12,
  parameter int HUGE_TOP = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [VA_W-1:0]    reqVaddr,
  input  logic               reqWrite,
  input  logic               reqUser,
  input  logic [VA_W-1:0]    rootBase,
  output logic               busy,
  output logic               memReqValid,
  input  logic               memReqReady,
  output logic [PA_W-1:0]    memReqAddr,
  input  logic               memRspValid,
  input  logic [ENTRY_W-1:0] memRspData,
  output logic               rspValid,
  input  logic               rspReady,
  output logic [PA_W-1:0]    rspPaddr,
  output logic               rspFault,
  output logic [1:0]         rspCause,
  output logic [1:0]         rspSize
);

  localparam int CNT_W = $clog2(LEVELS + 1) + 1;

  walkStrobe_t strobe;
  logic        inCanonical, entryPresent, entryPermOk, entryHuge, atLeaf;
  faultCause_t causeOut;
  pageSize_t   sizeOut;

  pt_walk_control u_control (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .inCanonical (inCanonical),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .entryPresent(entryPresent),
    .entryPermOk (entryPermOk),
    .entryHuge   (entryHuge),
    .atLeaf      (atLeaf),
    .rspReady    (rspReady),
    .strobe      (strobe),
    .busy        (busy),
    .memReqValid (memReqValid),
    .rspValid    (rspValid)
  );

  pt_walk_datapath #(
    .VA_W(VA_W), .PA_W(PA_W), .ENTRY_W(ENTRY_W), .LEVELS(LEVELS),
    .IDX_W(IDX_W), .OFF_W(OFF_W), .HUGE_TOP(HUGE_TOP)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqVaddr    (reqVaddr),
    .reqWrite    (reqWrite),
    .reqUser     (reqUser),
    .rootBase    (rootBase),
    .memRspData  (memRspData),
    .inCanonical (inCanonical),
    .entryPresent(entryPresent),
    .entryPermOk (entryPermOk),
    .entryHuge   (entryHuge),
    .atLeaf      (atLeaf),
    .memReqAddr  (memReqAddr),
    .rspPaddr    (rspPaddr),
    .rspCause    (causeOut),
    .rspSize     (sizeOut)
  );

  assign rspCause = causeOut;
  assign rspSize  = sizeOut;
  assign rspFault = (causeOut != CAUSE_NONE);

  // reads issued since the current request was accepted
  logic [CNT_W-1:0] readCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       readCnt <= '0;
    else if (reqValid && !busy)      readCnt <= '0;
    else if (memReqValid && memReqReady) readCnt <= readCnt + 1'b1;
  end

  AST_NONCANON_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspCause == CAUSE_NONCANON |-> readCnt == '0); // R2

  AST_WALK_DEPTH: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> int'(readCnt) <= LEVELS); // R3

  AST_READS_MATCH_SIZE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspFault |-> int'(readCnt) == LEVELS - int'(rspSize)); // R6

  AST_MEMADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> $stable(memReqAddr)); // R11

  AST_RSP_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> $stable(rspPaddr) && $stable(rspCause) && $stable(rspSize)); // R10

endmodule

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [63:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic        reqUser = 1'b0;
  logic [63:0] rootBase = 64'h1000;
  logic        busy, memReqValid, rspValid, rspFault;
  logic        memReqReady = 1'b1;
  logic [47:0] memReqAddr, rspPaddr;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic        rspReady = 1'b1;
  logic [1:0]  rspCause, rspSize;

  int total = 0;
  int bad = 0;
  int reads = 0;
  bit stallMode = 1'b0;

  always #10 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr),
    .reqWrite(reqWrite), .reqUser(reqUser), .rootBase(rootBase),
    .busy(busy), .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqAddr(memReqAddr), .memRspValid(memRspValid), .memRspData(memRspData),
    .rspValid(rspValid), .rspReady(rspReady), .rspPaddr(rspPaddr),
    .rspFault(rspFault), .rspCause(rspCause), .rspSize(rspSize)
  );

  // table contents: root at 0x1000, then 0x2000 / 0x3000 / 0x4000
  function automatic logic [63:0] tableEntry(input logic [47:0] a);
    case (a)
      48'h1000: return 64'h2007;
      48'h1FF8: return 64'h2003;
      48'h2000: return 64'h3007;
      48'h2008: return 64'hC0_0000_0087;
      48'h2010: return 64'h3005;
      48'h3000: return 64'h4007;
      48'h3008: return 64'h60_0087;
      48'h4000: return 64'hABCD_E007;
      48'h4008: return 64'h7003;
      48'h4018: return 64'h9087;
      default:  return 64'h0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: one reply per accepted read
  initial begin
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      if (memReqValid) begin
        logic [47:0] a;
        a = memReqAddr;
        if (stallMode) begin
          repeat (2) @(negedge clk);
          chk("R11 held valid", {63'd0, memReqValid}, 64'd1);
          chk("R11 held addr", {16'd0, memReqAddr}, {16'd0, a});
          memReqReady = 1'b1;
          @(negedge clk);
          memReqReady = 1'b0;
        end else begin
          @(negedge clk);
        end
        reads++;
        memRspValid = 1'b1;
        memRspData  = tableEntry(a);
      end
    end
  end

  task automatic walk(input logic [63:0] va, input logic wr, input logic us);
    reads = 0;
    @(negedge clk);
    reqVaddr = va; reqWrite = wr; reqUser = us; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (!rspValid) @(negedge clk);
  endtask

  typedef struct packed {
    logic [63:0] va;
    logic        wr;
    logic        us;
    logic [1:0]  cause;
    logic [47:0] pa;
    logic [1:0]  size;
    logic [2:0]  nReads;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{64'h0000_0000_0000_0123, 1'b0, 1'b1, 2'd0, 48'hABCD_E123, 2'd0, 3'd4}, // R3 R4
    '{64'h0000_0000_0000_1456, 1'b1, 1'b0, 2'd0, 48'h7456,      2'd0, 3'd4}, // R4 R8
    '{64'h0000_0000_0000_1456, 1'b0, 1'b1, 2'd3, 48'h0,         2'd0, 3'd4}, // R8
    '{64'h0000_0000_0021_2345, 1'b1, 1'b1, 2'd0, 48'h61_2345,   2'd1, 3'd3}, // R6
    '{64'h0000_0000_4123_4567, 1'b0, 1'b0, 2'd0, 48'hC0_0123_4567, 2'd2, 3'd2}, // R6
    '{64'h0000_0080_0000_0000, 1'b0, 1'b0, 2'd2, 48'h0,         2'd0, 3'd1}, // R5
    '{64'h0000_0000_0040_0000, 1'b0, 1'b0, 2'd2, 48'h0,         2'd0, 3'd3}, // R5
    '{64'h0000_0000_8000_0000, 1'b1, 1'b0, 2'd3, 48'h0,         2'd0, 3'd2}, // R8
    '{64'h0000_0000_8000_0000, 1'b0, 1'b1, 2'd0, 48'hABCD_E000, 2'd0, 3'd4}, // R8
    '{64'h0000_8000_0000_0000, 1'b0, 1'b0, 2'd1, 48'h0,         2'd0, 3'd0}, // R2
    '{64'h0001_0000_0000_0000, 1'b0, 1'b0, 2'd1, 48'h0,         2'd0, 3'd0}, // R2
    '{64'hFFFF_FF80_0000_0000, 1'b0, 1'b0, 2'd0, 48'hABCD_E000, 2'd0, 3'd4}, // R2 R3
    '{64'hFFFF_FF80_0000_0000, 1'b0, 1'b1, 2'd3, 48'h0,         2'd0, 3'd1}, // R8
    '{64'h0000_0000_0000_30AB, 1'b1, 1'b1, 2'd0, 48'h90AB,      2'd0, 3'd4}  // R7
  };

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", {63'd0, busy}, 64'd0);
    chk("R1 memReqValid", {63'd0, memReqValid}, 64'd0);
    chk("R1 rspValid", {63'd0, rspValid}, 64'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      walk(VECS[i].va, VECS[i].wr, VECS[i].us);
      chk($sformatf("R2/R5/R8 cause vec%0d", i), {62'd0, rspCause}, {62'd0, VECS[i].cause});
      chk($sformatf("R10 fault flag vec%0d", i), {63'd0, rspFault}, {63'd0, VECS[i].cause != 2'd0});
      chk($sformatf("R3 read count vec%0d", i), 64'(reads), {61'd0, VECS[i].nReads});
      if (VECS[i].cause == 2'd0) begin
        chk($sformatf("R4/R6/R7 paddr vec%0d", i), {16'd0, rspPaddr}, {16'd0, VECS[i].pa});
        chk($sformatf("R6 size vec%0d", i), {62'd0, rspSize}, {62'd0, VECS[i].size});
      end
      @(negedge clk);
    end

    // R9: second request during a walk is ignored
    reads = 0;
    @(negedge clk);
    reqVaddr = 64'h123; reqWrite = 1'b0; reqUser = 1'b0; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    chk("R9 busy during walk", {63'd0, busy}, 64'd1);
    reqVaddr = 64'h1456; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    rspReady = 1'b0;
    while (!rspValid) @(negedge clk);
    chk("R9 first request wins", {16'd0, rspPaddr}, 64'hABCD_E123);
    chk("R9 no extra reads", 64'(reads), 64'd4);
    // R10: result holds while not taken
    repeat (3) @(negedge clk);
    chk("R10 valid held", {63'd0, rspValid}, 64'd1);
    chk("R10 paddr held", {16'd0, rspPaddr}, 64'hABCD_E123);
    chk("R9 busy until handshake", {63'd0, busy}, 64'd1);
    rspReady = 1'b1;
    @(negedge clk);
    chk("R9 idle after handshake", {63'd0, busy}, 64'd0);
    repeat (2) @(negedge clk);
    chk("R9 ignored request not started", {63'd0, memReqValid}, 64'd0);

    // R11: memory back-pressure on a 2 MiB walk
    stallMode = 1'b1;
    memReqReady = 1'b0;
    walk(64'h0000_0000_0021_2345, 1'b0, 1'b0);
    chk("R11 paddr under stall", {16'd0, rspPaddr}, 64'h61_2345);
    chk("R11 reads under stall", 64'(reads), 64'd3);
    @(negedge clk);
    stallMode = 1'b0;
    memReqReady = 1'b1;

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule